// File: doc/BRIEF.md
# Frame-Checked Configuration Loader

This block takes in configuration content as a stream of fixed-length frames over a valid/ready input. Each frame is a parameterised number of 16-bit data words followed by one 16-bit check word. While a frame streams in, a parallel CRC engine folds in one data word per accepted transfer. The data words go into a frame memory. When the check word arrives, the block compares it with the computed value.

On a match, the computed 16 check bits go into a dedicated check store that holds one entry per frame, and loading moves on to the next frame. The first mismatch ends the whole load. The block then raises a sticky error flag, reports the index of the failing frame, and stops accepting input until reset. When the final frame matches, a one-cycle done pulse is issued and the block goes quiet.

A downstream consumer reads the frame memory and the check store through two combinational read ports.

Top module: `cfg_frame_loader`

## Requirements
- R1: While reset is high, and in the cycle after it, in_ready is 1, config_done is 0, config_error is 0 and err_frame is 0.
- R2: The CRC uses polynomial 0x1021 (x^16+x^12+x^5+1) with seed 0xFFFF. Each word is shifted in MSB first, one 16-bit word per accepted transfer. The CRC restarts from the seed at the first word of every frame.
- R3: A frame is FRAME_WORDS data words followed by one check word. Data word i of frame f is stored at frame-memory address f*FRAME_WORDS+i and is readable on rd_data when rd_addr selects it.
- R4: When a frame's check word equals the computed CRC, the check-store entry for that frame index holds the computed CRC, readable on chk_data when chk_idx selects it.
- R5: A word is taken only in a cycle where in_valid and in_ready are both 1. Cycles with in_valid low have no effect on storage or on frame progress.
- R6: If the last frame (index NUM_FRAMES-1) matches, config_done is 1 for exactly the one cycle after the accepting edge. After that, in_ready and config_done stay 0, and further input leaves the memories unchanged.
- R7: On the first check-word mismatch, config_error becomes 1 from the next cycle and stays 1. err_frame holds the failing frame index. in_ready stays 0 until reset. The check-store entry of the failing frame is not written, and later input leaves the memories unchanged.
- R8: A reset after an error or after completion starts a fresh load at frame 0 with a fresh CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 16 | Stream word (data or check word) |
| in_valid | input | 1 | in_data holds a word |
| in_ready | output | 1 | Block accepts a word this cycle |
| config_done | output | 1 | One-cycle pulse: all frames loaded and matched |
| config_error | output | 1 | Sticky mismatch flag |
| err_frame | output | FIDX_W | Index of the frame that failed its check |
| rd_addr | input | AW | Frame-memory read address |
| rd_data | output | 16 | Frame-memory read data |
| chk_idx | input | FIDX_W | Check-store read index |
| chk_data | output | 16 | Check-store read data |

## Verification
The hardest case to reach is showing that a failing frame leaves its check-store entry untouched. After reset the store holds unknown values, so there is nothing to compare against. The bench therefore first completes a clean load with one data pattern and then resets, which keeps memory contents. It next runs a second load with a different pattern whose second frame carries a corrupted check word. The entry for that frame must still hold the first load's value, while frame 0's entry must show the new one. Words pushed after the failure must not reach the frame memory, which the bench confirms by reading back the third frame's region.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    localparam int          WORD_W   = 16;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_DONE = 2'd1,
        ST_IDLE = 2'd2,
        ST_FAIL = 2'd3
    } ld_state_t;

    // Per-cycle transfer classification produced by the sequencer
    typedef struct packed {
        logic take_data;   // a data word is accepted
        logic take_chk;    // a check word is accepted
        logic chk_ok;      // accepted check word equals computed CRC
    } beat_t;

    // Fold one 16-bit word into the CRC, MSB first
    function automatic logic [15:0] crc16_step(input logic [15:0] cur,
                                               input logic [15:0] word);
        logic [15:0] r;
        logic        fb;
        r = cur;
        for (int b = WORD_W - 1; b >= 0; b--) begin
            fb = r[15] ^ word[b];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/cfgld_crc16.sv
module cfgld_crc16 (
    input  logic        clk,
    input  logic        rst,
    input  logic        restart,
    input  logic        update,
    input  logic [15:0] word,
    output logic [15:0] crc_q
);
    import cfgld_pkg::*;

    logic [15:0] crc_next;

    always_comb begin
        crc_next = crc16_step(crc_q, word);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            crc_q <= CRC_SEED;
        end else if (update) begin
            crc_q <= crc_next;
        end
    end
endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq #(
    parameter int FRAME_WORDS = 8,
    parameter int NUM_FRAMES  = 4,
    localparam int FIDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
    localparam int WIDX_W = $clog2(FRAME_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [15:0]       in_data,
    input  logic [15:0]       crc_q,
    output logic              in_ready,
    output cfgld_pkg::beat_t  beat,
    output logic [WIDX_W-1:0] word_idx,
    output logic [FIDX_W-1:0] frame_idx,
    output logic              config_done,
    output logic              config_error,
    output logic [FIDX_W-1:0] err_frame
);
    import cfgld_pkg::*;

    localparam logic [WIDX_W-1:0] CHK_SLOT   = WIDX_W'(FRAME_WORDS);
    localparam logic [FIDX_W-1:0] LAST_FRAME = FIDX_W'(NUM_FRAMES - 1);

    ld_state_t state_q;
    logic      accept;
    logic      at_chk;
    logic      is_last;

    always_comb begin
        in_ready       = (state_q == ST_LOAD);
        accept         = in_valid && in_ready;
        at_chk         = (word_idx == CHK_SLOT);
        is_last        = (frame_idx == LAST_FRAME);
        beat.take_data = accept && !at_chk;
        beat.take_chk  = accept && at_chk;
        beat.chk_ok    = (in_data == crc_q);
        config_done    = (state_q == ST_DONE);
        config_error   = (state_q == ST_FAIL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_LOAD;
            word_idx  <= '0;
            frame_idx <= '0;
            err_frame <= '0;
        end else begin
            unique case (state_q)
                ST_LOAD: begin
                    if (beat.take_data) begin
                        word_idx <= word_idx + 1'b1;
                    end else if (beat.take_chk) begin
                        if (beat.chk_ok) begin
                            word_idx <= '0;
                            if (is_last) begin
                                state_q <= ST_DONE;
                            end else begin
                                frame_idx <= frame_idx + 1'b1;
                            end
                        end else begin
                            state_q   <= ST_FAIL;
                            err_frame <= frame_idx;
                        end
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                ST_IDLE: state_q <= ST_IDLE;
                ST_FAIL: state_q <= ST_FAIL;
                default: state_q <= ST_FAIL;
            endcase
        end
    end
endmodule

// File: rtl/cfgld_store.sv
module cfgld_store #(
    parameter int FRAME_WORDS = 8,
    parameter int NUM_FRAMES  = 4,
    localparam int FIDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
    localparam int DEPTH  = FRAME_WORDS * NUM_FRAMES,
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              data_we,
    input  logic [AW-1:0]     data_addr,
    input  logic [15:0]       data_wd,
    input  logic              chk_we,
    input  logic [FIDX_W-1:0] chk_waddr,
    input  logic [15:0]       chk_wd,
    input  logic [AW-1:0]     rd_addr,
    output logic [15:0]       rd_data,
    input  logic [FIDX_W-1:0] chk_idx,
    output logic [15:0]       chk_data
);
    logic [15:0] frame_mem [DEPTH];
    logic [15:0] chk_mem   [NUM_FRAMES];

    always_ff @(posedge clk) begin
        if (data_we) frame_mem[data_addr] <= data_wd;
    end

    always_ff @(posedge clk) begin
        if (chk_we) chk_mem[chk_waddr] <= chk_wd;
    end

    always_comb begin
        rd_data  = frame_mem[rd_addr];
        chk_data = chk_mem[chk_idx];
    end
endmodule

// File: rtl/cfg_frame_loader.sv
module cfg_frame_loader #(
    parameter int FRAME_WORDS = 8,
    parameter int NUM_FRAMES  = 4,
    localparam int FIDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
    localparam int DEPTH  = FRAME_WORDS * NUM_FRAMES,
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int WIDX_W = $clog2(FRAME_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              config_done,
    output logic              config_error,
    output logic [FIDX_W-1:0] err_frame,
    input  logic [AW-1:0]     rd_addr,
    output logic [15:0]       rd_data,
    input  logic [FIDX_W-1:0] chk_idx,
    output logic [15:0]       chk_data
);
    import cfgld_pkg::*;

    beat_t             beat;
    logic [15:0]       crc_q;
    logic [WIDX_W-1:0] word_idx;
    logic [FIDX_W-1:0] frame_idx;
    logic              data_we;
    logic              chk_we;
    logic [AW-1:0]     data_addr;

    always_comb begin
        data_we   = beat.take_data;
        chk_we    = beat.take_chk && beat.chk_ok;
        data_addr = AW'(frame_idx) * AW'(FRAME_WORDS) + AW'(word_idx);
    end

    cfgld_seq #(
        .FRAME_WORDS(FRAME_WORDS),
        .NUM_FRAMES (NUM_FRAMES)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .crc_q       (crc_q),
        .in_ready    (in_ready),
        .beat        (beat),
        .word_idx    (word_idx),
        .frame_idx   (frame_idx),
        .config_done (config_done),
        .config_error(config_error),
        .err_frame   (err_frame)
    );

    cfgld_crc16 u_crc (
        .clk    (clk),
        .rst    (rst),
        .restart(beat.take_chk),
        .update (beat.take_data),
        .word   (in_data),
        .crc_q  (crc_q)
    );

    cfgld_store #(
        .FRAME_WORDS(FRAME_WORDS),
        .NUM_FRAMES (NUM_FRAMES)
    ) u_store (
        .clk      (clk),
        .data_we  (data_we),
        .data_addr(data_addr),
        .data_wd  (in_data),
        .chk_we   (chk_we),
        .chk_waddr(frame_idx),
        .chk_wd   (crc_q),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .chk_idx  (chk_idx),
        .chk_data (chk_data)
    );
endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker #(
    parameter int FIDX_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              config_done,
    input logic              config_error,
    input logic [FIDX_W-1:0] err_frame,
    input logic              data_we,
    input logic              chk_we
);
    // R1: outputs return to their idle values right after reset
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (in_ready && !config_done && !config_error && err_frame == '0));

    // R5: storage is written only on a real handshake
    assert_write_needs_handshake_R5: assert property (@(posedge clk) disable iff (rst)
        data_we |-> (in_valid && in_ready));

    // R4: a check-store write is never followed by an error
    assert_chk_write_only_on_match_R4: assert property (@(posedge clk) disable iff (rst)
        chk_we |=> !config_error);

    // R6: done is a single-cycle pulse and the block stops accepting
    assert_done_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        config_done |=> (!config_done && !in_ready));

    // R6: done and error are exclusive
    assert_done_not_error_R6: assert property (@(posedge clk) disable iff (rst)
        config_done |-> !config_error);

    // R7: error is sticky and its frame index is held
    assert_error_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        config_error |=> (config_error && $stable(err_frame)));

    // R7: no input accepted while in error
    assert_error_blocks_input_R7: assert property (@(posedge clk) disable iff (rst)
        config_error |-> (!in_ready && !data_we && !chk_we));
endmodule

bind cfg_frame_loader cfgld_checker #(.FIDX_W(FIDX_W)) u_checker (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .config_done (config_done),
    .config_error(config_error),
    .err_frame   (err_frame),
    .data_we     (data_we),
    .chk_we      (chk_we)
);

// File: tb/cfg_frame_loader_test.sv
`timescale 1ns/1ps
module cfg_frame_loader_test;
    localparam int FW    = 8;
    localparam int NF    = 4;
    localparam int FIW   = 2;
    localparam int DEPTH = FW * NF;
    localparam int AW    = 5;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [15:0]    in_data = '0;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic           config_done;
    logic           config_error;
    logic [FIW-1:0] err_frame;
    logic [AW-1:0]  rd_addr = '0;
    logic [15:0]    rd_data;
    logic [FIW-1:0] chk_idx = '0;
    logic [15:0]    chk_data;

    int n_run  = 0;
    int n_fail = 0;

    logic [15:0] exp_mem [DEPTH];
    logic [15:0] exp_chk [NF];

    always #4 clk = ~clk;

    cfg_frame_loader #(.FRAME_WORDS(FW), .NUM_FRAMES(NF)) uut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .config_done(config_done),
        .config_error(config_error), .err_frame(err_frame),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .chk_idx(chk_idx), .chk_data(chk_data)
    );

    // Reference CRC: x^16+x^12+x^5+1, MSB first, per requirement R2
    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] w);
        logic [15:0] s = c;
        for (int k = 0; k < 16; k++) begin
            logic in_bit = w[15 - k];
            logic top    = s[15];
            s = {s[14:0], 1'b0} ^ ((top ^ in_bit) ? 16'h1021 : 16'h0000);
        end
        return s;
    endfunction

    function automatic logic [15:0] pattern(input int seed, input int f, input int i);
        return 16'((seed * 40503) ^ (f * 4099) ^ (i * 7919) ^ (i << 9));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a negedge; one word offered for one edge, then gap idle cycles
    task automatic push(input logic [15:0] w, input int gap);
        in_data  = w;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        for (int g = 0; g < gap; g++) @(negedge clk);
    endtask

    // Sends one frame; optional corruption of the check word
    task automatic send_frame(input int seed, input int f, input bit bad, input int gap,
                              input bit record);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < FW; i++) begin
            logic [15:0] w = pattern(seed, f, i);
            c = ref_crc(c, w);
            if (record) exp_mem[f * FW + i] = w;
            push(w, gap);
        end
        if (record && !bad) exp_chk[f] = c;
        push(bad ? (c ^ 16'h0040) : c, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic verify_mem(input string tag);
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = AW'(a);
            #1;
            check(tag, {16'h0, rd_data}, {16'h0, exp_mem[a]});
        end
    endtask

    task automatic verify_chk(input string tag, input int f);
        chk_idx = FIW'(f);
        #1;
        check(tag, {16'h0, chk_data}, {16'h0, exp_chk[f]});
    endtask

    task automatic test_reset();
        do_reset();
        check("R1 ready", {31'h0, in_ready}, 32'd1);
        check("R1 done", {31'h0, config_done}, 32'd0);
        check("R1 error", {31'h0, config_error}, 32'd0);
        check("R1 err_frame", {30'h0, err_frame}, 32'd0);
    endtask

    task automatic test_good_load(input int seed, input int gap, input string tag);
        do_reset();
        for (int f = 0; f < NF - 1; f++) begin
            send_frame(seed, f, 1'b0, gap, 1'b1);
            check({tag, " R5 ready mid-load"}, {31'h0, in_ready}, 32'd1);
            check({tag, " R6 no early done"}, {31'h0, config_done}, 32'd0);
        end
        send_frame(seed, NF - 1, 1'b0, gap, 1'b1);
        check({tag, " R6 done pulse"}, {31'h0, config_done}, 32'd1);
        check({tag, " R6 ready low"}, {31'h0, in_ready}, 32'd0);
        @(negedge clk);
        check({tag, " R6 done ends"}, {31'h0, config_done}, 32'd0);
        check({tag, " R6 no error"}, {31'h0, config_error}, 32'd0);
        verify_mem({tag, " R3 frame data"});
        for (int f = 0; f < NF; f++) verify_chk({tag, " R2 R4 check store"}, f);
    endtask

    task automatic test_ignore_after_done();
        for (int i = 0; i < 6; i++) push(16'hDEAD ^ 16'(i), 0);
        check("R6 ready stays low", {31'h0, in_ready}, 32'd0);
        check("R6 done stays low", {31'h0, config_done}, 32'd0);
        verify_mem("R6 memory untouched");
        verify_chk("R6 check store untouched", 0);
    endtask

    task automatic test_bad_middle();
        do_reset();
        send_frame(21, 0, 1'b0, 0, 1'b1);
        send_frame(21, 1, 1'b1, 1, 1'b1);
        check("R7 error raised", {31'h0, config_error}, 32'd1);
        check("R7 err_frame", {30'h0, err_frame}, 32'd1);
        check("R7 ready dropped", {31'h0, in_ready}, 32'd0);
        check("R7 no done", {31'h0, config_done}, 32'd0);
        // later input must not reach frame 2 or the check store
        send_frame(21, 2, 1'b0, 0, 1'b0);
        check("R7 error sticky", {31'h0, config_error}, 32'd1);
        check("R7 err_frame held", {30'h0, err_frame}, 32'd1);
        verify_mem("R7 memory after error");
        verify_chk("R4 new entry frame 0", 0);
        verify_chk("R7 failing entry kept", 1);
        verify_chk("R7 later entry kept", 2);
    endtask

    task automatic test_bad_last();
        do_reset();
        for (int f = 0; f < NF - 1; f++) send_frame(33, f, 1'b0, 0, 1'b1);
        send_frame(33, NF - 1, 1'b1, 0, 1'b1);
        check("R7 last frame error", {31'h0, config_error}, 32'd1);
        check("R7 last err_frame", {30'h0, err_frame}, 32'(NF - 1));
        check("R7 no done on bad last", {31'h0, config_done}, 32'd0);
        repeat (3) @(negedge clk);
        check("R7 still error", {31'h0, config_error}, 32'd1);
        check("R7 still no done", {31'h0, config_done}, 32'd0);
    endtask

    task automatic test_bad_first_then_restart();
        do_reset();
        send_frame(44, 0, 1'b1, 0, 1'b1);
        check("R7 first frame error", {31'h0, config_error}, 32'd1);
        check("R7 first err_frame", {30'h0, err_frame}, 32'd0);
        test_reset();
        test_good_load(55, 0, "R8 restart");
    endtask

    initial begin
        test_reset();
        test_good_load(7, 0, "back-to-back");
        test_ignore_after_done();
        test_good_load(9, 2, "R5 gapped");
        test_bad_middle();
        test_bad_last();
        test_bad_first_then_restart();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule